// File: doc/BRIEF.md
# Serial Slave Reset Sequencer

This block brings a serial slave device back to a known state without any help from the slave's own reset pin. On a start pulse it takes the serial pins away from the normal transfer engine: it switches off the priority arbiter, the normal transfer engine and dual-line data mode, then points the pin mux at its own manual command path and enables that path. It then issues seven manual command words in a fixed order. The slave counts the chip-select toggles this produces and resets its own serial interface.

After the last command the sequencer waits for the link's sync-idle indication. A timeout counter, built from a clock-cycles-per-microsecond prescaler, bounds the wait. Whether sync-idle arrives or the wait expires, the block drops the manual enable and the mux select, which hands the pins back to the normal engine. It then pulses `done_o`, with `err_o` marking a timeout.

Each manual command word is decoded by a small executor that drives the chip-select, clock and data pins. A copy of every word is also visible at the ports as it is issued.

Top module: `slave_reset_seq`

## Requirements
- R1: After reset: `done_o`=0, `err_o`=0, `spi_cs_n_o`=1, `spi_sclk_o`=0, `spi_sdo_o`=0, `man_en_o`=0, `mux_sel_o`=0, `man_cmd_vld_o`=0. The engine-owned settings `arb_en_o`, `wrap_en_o` and `dual_io_o` are all 1.
- R2: One cycle after `start_i` is sampled high in idle, the following hold, and they stay so while commands are issued:
  - `arb_en_o`, `wrap_en_o` and `dual_io_o` are 0.
  - `mux_sel_o` and `man_en_o` are 1.
- R3: A manual command word is 16 bits:
  - bit 13 is the write flag, always 1 here;
  - bits 11:8 hold the opcode: chip-select high = 0, chip-select low = 1, single-line shift-out = 8;
  - bits 7:0 are the shift data, 0 here;
  - all other bits are 0.
- R4: Exactly seven words are issued per run, in this order: chip-select low, shift-out, chip-select high, shift-out, shift-out, shift-out, shift-out. These are 0x2100, 0x2800, 0x2000, 0x2800, 0x2800, 0x2800, 0x2800.
- R5: Each shift-out gives 8 rising edges of `spi_sclk_o` with `spi_sdo_o`=0, and `spi_cs_n_o` does not change during it. Per run this gives:
  - chip-select falls once, before the first clock edge;
  - the first 8 clock edges occur with chip-select low;
  - chip-select rises after edge 8;
  - the remaining 32 edges occur with chip-select high.
- R6: `sync_idle_i` is ignored until the last shift-out has finished. With it held high from before start, `done_o` still comes after the final clock edge.
- R7: If `sync_idle_i` is high during the wait, `done_o` pulses with `err_o`=0 no more than 3 cycles after it rises.
- R8: If `sync_idle_i` stays low for TIMEOUT_US×CLKS_PER_US cycles of the wait, `done_o` pulses with `err_o`=1. This happens between that count and that count plus 6 cycles after the final clock edge falls.
- R9: When `done_o` is high, `man_en_o` and `mux_sel_o` are 0, whether or not the wait timed out. `arb_en_o`, `wrap_en_o` and `dual_io_o` remain 0.
- R10: `done_o` is a one-cycle pulse. `err_o` holds its value until the next start.
- R11: A start pulse while a run is in progress is ignored. The run still produces exactly one chip-select fall, 40 clock edges and seven words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| sync_idle_i | input | 1 | Link reports sync-idle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Wait timed out in the last run |
| arb_en_o | output | 1 | Priority arbiter enable |
| wrap_en_o | output | 1 | Normal transfer engine enable |
| mux_sel_o | output | 1 | Pin mux: 1 selects manual path |
| man_en_o | output | 1 | Manual command path enable |
| dual_io_o | output | 1 | Dual-line data mode enable |
| man_cmd_o | output | 16 | Manual command word being issued |
| man_cmd_vld_o | output | 1 | Qualifies `man_cmd_o` for one cycle |
| spi_cs_n_o | output | 1 | Slave chip-select, active low |
| spi_sclk_o | output | 1 | Slave serial clock |
| spi_sdo_o | output | 1 | Slave serial data out |

## Verification
The bench goes after four corner cases:
- **Sync-idle before the wait.** It holds sync-idle high for a whole run. A sequencer that sampled it too early would finish before the shift-outs and the slave would never reset.
- **The timeout boundary.** It places sync-idle 20 cycles inside and 20 cycles outside the timeout window. A prescaler that is off by a factor, or a counter that never saturates, would flip the error flag on one of the two.
- **A second start mid-run.** It pulses start again while clocks are running. A design that restarted would show extra chip-select edges or more than 40 clocks.
- **The pin hand-back after a timeout.** It checks the manual enable and mux select after a timed-out run. A design that released the pins only on success would leave the slave pins stuck on the manual path.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int CMD_W  = 16;
    localparam int WR_BIT = 13;
    localparam int OP_LSB = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CS_HI = 4'h0,
        OP_CS_LO = 4'h1,
        OP_SHIFT = 4'h8
    } man_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ISSUE,
        ST_HOLD,
        ST_DRAIN,
        ST_SYNC
    } seq_st_e;

    // Build a write-flagged manual command with zero shift data.
    function automatic logic [CMD_W-1:0] pack_cmd(man_op_e op);
        logic [CMD_W-1:0] w;
        w = '0;
        w[WR_BIT] = 1'b1;
        w[OP_LSB +: OP_W] = op;
        return w;
    endfunction

    // Fixed ordering: low, shift, high, then shifts for the rest.
    function automatic man_op_e op_at(int idx);
        case (idx)
            0:       return OP_CS_LO;
            2:       return OP_CS_HI;
            default: return OP_SHIFT;
        endcase
    endfunction

endpackage

// File: rtl/srs_us_timer.sv
module srs_us_timer #(
    parameter int CLKS_PER_US = 100,
    parameter int LIMIT_US    = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam int UW = $clog2(LIMIT_US + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);
    localparam logic [UW-1:0] US_LAST  = UW'(LIMIT_US);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [UW-1:0] us;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d = '0;
        end else if (tmr_q.us != US_LAST) begin
            if (tmr_q.pre == PRE_LAST) begin
                tmr_d.pre = '0;
                tmr_d.us  = tmr_q.us + 1'b1;
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = (tmr_q.us == US_LAST);

    AST_US_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.us <= US_LAST);                                          // R8
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.pre <= PRE_LAST);                                        // R8
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tmr_q.us == '0));                                  // R8

endmodule

// File: rtl/srs_man_exec.sv
module srs_man_exec
    import srs_pkg::*;
#(
    parameter int SHIFT_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             rdy_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sdo_o
);
    localparam int BCW = (SHIFT_BITS > 1) ? $clog2(SHIFT_BITS) : 1;
    localparam logic [BCW-1:0] BIT_LAST = BCW'(SHIFT_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic                  phase;
        logic [BCW-1:0]        bits;
        logic [SHIFT_BITS-1:0] sh;
        logic                  cs_n;
    } ex_t;

    ex_t ex_d, ex_q;

    logic          wr_flag;
    logic          legal;
    logic [OP_W-1:0] op;

    assign wr_flag = cmd_i[WR_BIT];
    assign op      = cmd_i[OP_LSB +: OP_W];
    assign legal   = (cmd_i[15:14] == 2'b00) && !cmd_i[12];

    always_comb begin
        ex_d = ex_q;
        if (ex_q.busy) begin
            if (!ex_q.phase) begin
                ex_d.phase = 1'b1;
            end else begin
                ex_d.phase = 1'b0;
                ex_d.sh    = ex_q.sh << 1;
                if (ex_q.bits == BIT_LAST) ex_d.busy = 1'b0;
                else                       ex_d.bits = ex_q.bits + 1'b1;
            end
        end else if (cmd_vld_i && wr_flag && legal) begin
            case (op)
                OP_CS_HI: ex_d.cs_n = 1'b1;
                OP_CS_LO: ex_d.cs_n = 1'b0;
                OP_SHIFT: begin
                    ex_d.busy  = 1'b1;
                    ex_d.phase = 1'b0;
                    ex_d.bits  = '0;
                    ex_d.sh    = cmd_i[SHIFT_BITS-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q      <= '0;
            ex_q.cs_n <= 1'b1;
        end else begin
            ex_q <= ex_d;
        end
    end

    assign rdy_o  = !ex_q.busy;
    assign cs_n_o = ex_q.cs_n;
    assign sclk_o = ex_q.busy && ex_q.phase;
    assign sdo_o  = ex_q.busy && ex_q.sh[SHIFT_BITS-1];

    AST_CS_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_q.busy && $past(ex_q.busy)) |-> $stable(ex_q.cs_n));     // R5
    AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_i |-> !ex_q.busy);                                     // R4
    AST_SCLK_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ex_q.busy) |-> !sclk_o);                                 // R5

endmodule

// File: rtl/slave_reset_seq.sv
module slave_reset_seq
    import srs_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int TIMEOUT_US  = 255,
    parameter int TAIL_SHIFTS = 4,
    parameter int SHIFT_BITS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        sync_idle_i,
    output logic        done_o,
    output logic        err_o,
    output logic        arb_en_o,
    output logic        wrap_en_o,
    output logic        mux_sel_o,
    output logic        man_en_o,
    output logic        dual_io_o,
    output logic [15:0] man_cmd_o,
    output logic        man_cmd_vld_o,
    output logic        spi_cs_n_o,
    output logic        spi_sclk_o,
    output logic        spi_sdo_o
);
    localparam int N_OPS = 3 + TAIL_SHIFTS;
    localparam int IW    = $clog2(N_OPS);
    localparam logic [IW-1:0] IDX_LAST = IW'(N_OPS - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [IW-1:0]    idx;
        logic [CMD_W-1:0] cmd;
        logic             vld;
        logic             done;
        logic             err;
        logic             arb;
        logic             wrap;
        logic             dio;
        logic             mux;
        logic             man;
    } seq_t;

    seq_t s_d, s_q;
    logic exec_rdy;
    logic expired;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.err  = 1'b0;
                    s_d.arb  = 1'b0;
                    s_d.wrap = 1'b0;
                    s_d.dio  = 1'b0;
                    s_d.mux  = 1'b1;
                    s_d.man  = 1'b1;
                    s_d.idx  = '0;
                    s_d.st   = ST_PREP;
                end
            end
            ST_PREP: s_d.st = ST_ISSUE;
            ST_ISSUE: begin
                if (exec_rdy) begin
                    s_d.cmd = pack_cmd(op_at(int'(s_q.idx)));
                    s_d.vld = 1'b1;
                    s_d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                s_d.vld = 1'b0;
                if (s_q.idx == IDX_LAST) begin
                    s_d.st = ST_DRAIN;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.st  = ST_ISSUE;
                end
            end
            ST_DRAIN: if (exec_rdy) s_d.st = ST_SYNC;
            ST_SYNC: begin
                if (sync_idle_i || expired) begin
                    s_d.err  = !sync_idle_i;
                    s_d.done = 1'b1;
                    s_d.man  = 1'b0;
                    s_d.mux  = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.arb  <= 1'b1;
            s_q.wrap <= 1'b1;
            s_q.dio  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    srs_man_exec #(.SHIFT_BITS(SHIFT_BITS)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld_i (s_q.vld),
        .cmd_i     (s_q.cmd),
        .rdy_o     (exec_rdy),
        .cs_n_o    (spi_cs_n_o),
        .sclk_o    (spi_sclk_o),
        .sdo_o     (spi_sdo_o)
    );

    srs_us_timer #(.CLKS_PER_US(CLKS_PER_US), .LIMIT_US(TIMEOUT_US)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.st == ST_SYNC),
        .expired_o (expired)
    );

    assign done_o        = s_q.done;
    assign err_o         = s_q.err;
    assign arb_en_o      = s_q.arb;
    assign wrap_en_o     = s_q.wrap;
    assign dual_io_o     = s_q.dio;
    assign mux_sel_o     = s_q.mux;
    assign man_en_o      = s_q.man;
    assign man_cmd_o     = s_q.cmd;
    assign man_cmd_vld_o = s_q.vld;

    AST_CMD_IN_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        man_cmd_vld_o |-> (man_en_o && mux_sel_o && !wrap_en_o && !arb_en_o && !dual_io_o)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                           // R10
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!man_en_o && !mux_sel_o));                         // R9
    AST_SYNC_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(sync_idle_i));                    // R7
    AST_DONE_AFTER_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!spi_sclk_o && exec_rdy));                         // R6
    AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(start_i)) |-> $stable(err_o));              // R10

endmodule

// File: tb/slave_reset_seq_test.sv
module slave_reset_seq_test;
    localparam int CPU   = 4;
    localparam int TUS   = 255;
    localparam int TCYC  = CPU * TUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sync_idle_i = 1'b0;
    logic done_o, err_o, arb_en_o, wrap_en_o, mux_sel_o, man_en_o, dual_io_o;
    logic [15:0] man_cmd_o;
    logic man_cmd_vld_o, spi_cs_n_o, spi_sclk_o, spi_sdo_o;

    always #5 clk = ~clk;

    slave_reset_seq #(.CLKS_PER_US(CPU), .TIMEOUT_US(TUS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sync_idle_i(sync_idle_i),
        .done_o(done_o), .err_o(err_o), .arb_en_o(arb_en_o), .wrap_en_o(wrap_en_o),
        .mux_sel_o(mux_sel_o), .man_en_o(man_en_o), .dual_io_o(dual_io_o),
        .man_cmd_o(man_cmd_o), .man_cmd_vld_o(man_cmd_vld_o),
        .spi_cs_n_o(spi_cs_n_o), .spi_sclk_o(spi_sclk_o), .spi_sdo_o(spi_sdo_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rise_cnt, low_rises, sdo_bad, cs_falls, cs_fall_at, cs_rise_at;
    int last_fall, ncmd, ndone, done_cyc, sync_cyc;
    logic done_err;
    logic [15:0] cmds [0:7];

    // delay (cycles after final clock fall, FFFF = never) and expected error
    localparam logic [16:0] VEC [0:5] = '{
        {16'd0,    1'b0},
        {16'd5,    1'b0},
        {16'd300,  1'b0},
        {16'd1000, 1'b0},
        {16'd1040, 1'b1},
        {16'hFFFF, 1'b1}
    };

    always @(posedge clk) cyc++;
    always @(posedge spi_sclk_o) begin
        rise_cnt++;
        if (!spi_cs_n_o) low_rises++;
        if (spi_sdo_o) sdo_bad++;
    end
    always @(negedge spi_cs_n_o) begin cs_falls++; cs_fall_at = rise_cnt; end
    always @(posedge spi_cs_n_o) cs_rise_at = rise_cnt;
    always @(negedge spi_sclk_o) last_fall = cyc;
    always @(negedge clk) begin
        if (man_cmd_vld_o) begin
            if (ncmd < 8) cmds[ncmd] = man_cmd_o;
            ncmd++;
        end
        if (done_o) begin ndone++; done_cyc = cyc; done_err = err_o; end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(int i);
        if (i == 0) return 16'h2100;
        if (i == 2) return 16'h2000;
        return 16'h2800;
    endfunction

    task automatic clear_mon();
        rise_cnt = 0; low_rises = 0; sdo_bad = 0; cs_falls = 0;
        cs_fall_at = -1; cs_rise_at = -1; last_fall = 0; ncmd = 0;
        ndone = 0; done_cyc = 0; sync_cyc = 0; done_err = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        for (int k = 0; k < 3000; k++) begin
            if (rise_cnt >= n) break;
            @(posedge clk);
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (ndone > 0) break;
        end
    endtask

    task automatic check_pins(input string tag);
        check(ncmd == 7, {"R4 word count ", tag}, ncmd, 7);
        for (int i = 0; i < 7; i++)
            check(cmds[i] == exp_cmd(i), {"R3 R4 word ", tag}, cmds[i], exp_cmd(i));
        check(rise_cnt == 40, {"R5 clock edges ", tag}, rise_cnt, 40);
        check(low_rises == 8, {"R5 edges with cs low ", tag}, low_rises, 8);
        check(sdo_bad == 0, {"R5 data line zero ", tag}, sdo_bad, 0);
        check(cs_falls == 1 && cs_fall_at == 0, {"R5 cs fall ", tag}, cs_fall_at, 0);
        check(cs_rise_at == 8 && spi_cs_n_o, {"R5 cs rise ", tag}, cs_rise_at, 8);
    endtask

    task automatic check_end(input string tag);
        check(!man_en_o && !mux_sel_o, {"R9 pins released ", tag},
              {man_en_o, mux_sel_o}, 0);
        check(!arb_en_o && !wrap_en_o && !dual_io_o, {"R9 engine stays off ", tag},
              {arb_en_o, wrap_en_o, dual_io_o}, 0);
        @(negedge clk);
        check(!done_o && ndone == 1, {"R10 done one pulse ", tag}, ndone, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R1 reset values
        check(!done_o && !err_o && spi_cs_n_o && !spi_sclk_o && !spi_sdo_o,
              "R1 reset outputs", {done_o, err_o, spi_cs_n_o, spi_sclk_o, spi_sdo_o}, 5'b00100);
        check(!man_en_o && !mux_sel_o && !man_cmd_vld_o && arb_en_o && wrap_en_o && dual_io_o,
              "R1 reset controls", {man_en_o, mux_sel_o, man_cmd_vld_o, arb_en_o, wrap_en_o, dual_io_o},
              6'b000111);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk over sync-idle placement
        for (int v = 0; v < 6; v++) begin
            int dly;
            logic xerr;
            dly  = int'(VEC[v][16:1]);
            xerr = VEC[v][0];
            clear_mon();
            sync_idle_i = 1'b0;
            pulse_start();
            check(!arb_en_o && !wrap_en_o && !dual_io_o && mux_sel_o && man_en_o,
                  "R2 takeover", {arb_en_o, wrap_en_o, dual_io_o, mux_sel_o, man_en_o}, 5'b00011);
            wait_rises(40);
            @(negedge spi_sclk_o);
            if (dly != 16'hFFFF) begin
                repeat (dly) @(posedge clk);
                #1 sync_idle_i = 1'b1;
                sync_cyc = cyc;
            end
            wait_done();
            check_pins($sformatf("vec%0d", v));
            check(ndone == 1 && done_err == xerr, $sformatf("R7 R8 error flag vec%0d", v),
                  done_err, xerr);
            if (!xerr)
                check(done_cyc - sync_cyc <= 3 && done_cyc > sync_cyc,
                      $sformatf("R7 latency vec%0d", v), done_cyc - sync_cyc, 3);
            else
                check(done_cyc - last_fall >= TCYC && done_cyc - last_fall <= TCYC + 6,
                      $sformatf("R8 timeout window vec%0d", v), done_cyc - last_fall, TCYC);
            check_end($sformatf("vec%0d", v));
            repeat (10) @(negedge clk);
            check(err_o == xerr, $sformatf("R10 error held vec%0d", v), err_o, xerr);
            sync_idle_i = 1'b0;
        end

        // R6: sync-idle high from before start must not end the run early
        clear_mon();
        sync_idle_i = 1'b1;
        pulse_start();
        wait_done();
        check_pins("r6_sync_early");
        check(done_cyc > last_fall && rise_cnt == 40, "R6 done after shifts",
              done_cyc - last_fall, 1);
        check(!done_err, "R6 no error", done_err, 0);
        check_end("r6_sync_early");
        sync_idle_i = 1'b0;
        repeat (5) @(negedge clk);

        // R11: second start during shifting is ignored
        clear_mon();
        pulse_start();
        wait_rises(10);
        pulse_start();
        wait_rises(40);
        @(negedge spi_sclk_o);
        repeat (20) @(posedge clk);
        #1 sync_idle_i = 1'b1;
        wait_done();
        check_pins("r11_restart");
        check(cs_falls == 1 && ncmd == 7, "R11 no restart", cs_falls, 1);
        check_end("r11_restart");
        sync_idle_i = 1'b0;
        repeat (20) @(negedge clk);
        check(ndone == 1 && rise_cnt == 40, "R11 nothing after run", rise_cnt, 40);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule